// File: doc/BRIEF.md
# Serial Transmit Queue with Empty-Interrupt Hold-Back

This block is the sending half of a classic byte-oriented serial port. The host pushes bytes into a 16-deep queue over a valid/ready write channel. A framing shifter drains the queue one character at a time whenever it is idle. Each character is sent on a line that idles high, starting with a low start bit, followed by 5 to 8 data bits with the least significant bit first, an optional parity bit and one or two high stop bits. Bit timing comes from a one-cycle `bit_tick` pulse supplied from outside the block. The shifter moves to the next bit on every tick.

The interrupt request tells the host that the queue is empty. It has one refinement. When the queue empties after holding only a single byte, the request is held back for one full character time. This stops the host from seeing a fresh "empty" event while it is still writing the next byte. The hold-back stays armed until the queue has held two or more bytes at the same time. After that, the next emptying raises the request at once and the hold-back arms again. A synchronous queue clear discards waiting bytes and re-arms the hold-back. It does not affect a character that is already on the line.

The write channel follows valid/ready rules. A byte is taken on a rising clock edge where both `wr_valid` and `wr_ready` are high. `wr_ready` is low exactly when the queue holds 16 bytes, and the host may hold `wr_valid` high while `wr_ready` is low with no effect. `wr_valid` and `wr_data` do not need to stay stable while `wr_ready` is low.

Top module: `uart_txq_top`

## Requirements
- R1: The queue stores up to 16 bytes. At 16 bytes `wr_ready` is low and `fifo_full` is high. A `wr_valid` presented while `wr_ready` is low leaves the queue unchanged, and that byte never appears on `txd`.
- R2: When the queue is full, `wr_ready` returns high in the same cycle that the next character's start bit first appears on `txd`, that is, the cycle after a byte moves into the shifter.
- R3: `txd` idles high. A character starts with one low start bit in the cycle after a byte leaves the queue while the shifter is idle. Each later bit appears in the cycle after a `bit_tick`. The data bits go out least significant first, and their count is 5 + `word_len` (`word_len` 0 to 3). When `parity_en` is 1, a parity bit follows that makes the total number of ones over the data bits and the parity bit even. Then come one stop bit, or two when `two_stop` is 1.
- R4: `irq` is high only when the queue is empty and `irq_en` is high. After reset the queue is empty and the request is ready.
- R5: A byte accepted into an empty queue drives `irq` low in the next cycle.
- R6: If the queue empties without having held two bytes at once since the hold-back was last armed, `irq` stays low for L `bit_tick` pulses counted after the cycle the last byte left. L = 1 + (5 + `word_len`) + `parity_en` + (1 + `two_stop`). `irq` rises in the cycle after the L-th pulse. A write during the wait cancels it.
- R7: Once the queue has held two or more bytes at the same time, the next emptying raises `irq` in the cycle after the last byte leaves, with no delay. The hold-back then arms again for the next emptying.
- R8: Lowering `irq_en` drops `irq` in the same cycle. Raising it while the ready condition holds raises `irq` in the same cycle.
- R9: A one-cycle `fifo_clr` empties the queue and discards the waiting bytes. It raises `irq` in the next cycle if it is enabled, and it re-arms the hold-back. A character already being shifted still completes unchanged.
- R10: When `fifo_clr` and an accepted write fall in the same cycle, the clear wins and the written byte is never transmitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Host offers a byte |
| wr_data | input | 8 | Byte offered by the host |
| wr_ready | output | 1 | Queue can accept a byte this cycle |
| irq_en | input | 1 | Enables the empty interrupt |
| fifo_clr | input | 1 | Synchronous queue clear, one cycle |
| bit_tick | input | 1 | One-cycle pulse per serial bit period |
| word_len | input | 2 | Data bits minus five |
| parity_en | input | 1 | Append even parity bit |
| two_stop | input | 1 | Two stop bits instead of one |
| txd | output | 1 | Serial output, idle high |
| fifo_full | output | 1 | Queue holds 16 bytes |
| irq | output | 1 | Transmit-empty interrupt request |

## Verification
The assertions assume that `word_len`, `parity_en` and `two_stop` hold steady while a character is being shifted or a hold-back wait is running. They also assume that `bit_tick` is a single-cycle pulse. The stimulus changes the line settings only after the line has been idle for longer than the longest character. It generates `bit_tick` from a free-running divider as a single-cycle pulse every eight clocks, and it pulses `fifo_clr` for exactly one cycle while a character is in flight.

// File: rtl/uart_txq_pkg.sv
package uart_txq_pkg;

  localparam int unsigned DATA_W   = 8;
  localparam int unsigned FRAME_W  = DATA_W + 4;
  localparam int unsigned LEN_W    = $clog2(FRAME_W + 1);

  typedef struct packed {
    logic [1:0] wlen;
    logic       par_en;
    logic       stop2;
  } line_cfg_t;

  function automatic logic [LEN_W-1:0] char_ticks(input line_cfg_t c);
    logic [LEN_W-1:0] n;
    n = LEN_W'(1) + LEN_W'(5) + LEN_W'(c.wlen) + LEN_W'(c.par_en) + LEN_W'(1) + LEN_W'(c.stop2);
    return n;
  endfunction

endpackage

// File: rtl/txq_fifo.sv
module txq_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned WIDTH = 8,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push_valid,
  input  logic [WIDTH-1:0] push_data,
  output logic             push_ready,
  input  logic             pop_req,
  output logic [WIDTH-1:0] pop_data,
  output logic             pushed,
  output logic             popped,
  output logic [CW-1:0]    count
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    count_q;
  logic             empty;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign empty      = (count_q == '0);
  assign push_ready = (count_q != CW'(DEPTH));
  assign pushed     = push_valid && push_ready && !clr;
  assign popped     = pop_req && !empty && !clr;
  assign pop_data   = mem[rd_ptr];
  assign count      = count_q;

  always_ff @(posedge clk) begin
    if (pushed) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_q <= '0;
    end else begin
      if (pushed) wr_ptr <= ptr_next(wr_ptr);
      if (popped) rd_ptr <= ptr_next(rd_ptr);
      case ({pushed, popped})
        2'b10:   count_q <= count_q + CW'(1);
        2'b01:   count_q <= count_q - CW'(1);
        default: count_q <= count_q;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && !push_ready && !popped && !clr) |=> (count_q == CW'(DEPTH))); // R1

  AST_REOPEN_ON_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (!push_ready && popped) |=> push_ready); // R2

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count_q == '0)); // R9

  AST_CLEAR_BEATS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && push_valid) |=> (count_q == '0)); // R10

endmodule

// File: rtl/txq_shifter.sv
module txq_shifter
  import uart_txq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  line_cfg_t         cfg,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  output logic              busy,
  output logic              txd
);

  logic [FRAME_W-1:0] frame_q;
  logic [FRAME_W-1:0] built;
  logic [LEN_W-1:0]   left_q;
  logic               txd_q;
  logic               par;
  int unsigned        nbits;

  always_comb begin
    nbits = 5 + int'(cfg.wlen);
    built = '1;
    built[0] = 1'b0;
    par = 1'b0;
    for (int i = 0; i < int'(DATA_W); i++) begin
      if (i < int'(nbits)) begin
        built[i+1] = load_data[i];
        par = par ^ load_data[i];
      end
    end
    if (cfg.par_en) built[nbits+1] = par;
  end

  assign busy = (left_q != '0);
  assign txd  = txd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_q <= '1;
      left_q  <= '0;
      txd_q   <= 1'b1;
    end else if (load && !busy) begin
      txd_q   <= built[0];
      frame_q <= {1'b1, built[FRAME_W-1:1]};
      left_q  <= char_ticks(cfg);
    end else if (busy && tick) begin
      txd_q   <= frame_q[0];
      frame_q <= {1'b1, frame_q[FRAME_W-1:1]};
      left_q  <= left_q - LEN_W'(1);
    end
  end

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd); // R3

  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !busy) |=> (!txd && busy)); // R3

  AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> $stable(txd)); // R3

endmodule

// File: rtl/txq_irq_ctl.sv
module txq_irq_ctl
  import uart_txq_pkg::*;
#(
  parameter int unsigned CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          tick,
  input  line_cfg_t     cfg,
  input  logic          pushed,
  input  logic          popped,
  input  logic [CW-1:0] count,
  input  logic          irq_en,
  output logic          irq
);

  logic             seen_two_q;
  logic             ready_q;
  logic [LEN_W-1:0] wait_q;
  logic             last_out;

  assign last_out = popped && !pushed && (count == CW'(1));
  assign irq      = irq_en && ready_q && (count == '0);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      seen_two_q <= 1'b0;
      ready_q    <= 1'b1;
      wait_q     <= '0;
    end else begin
      if (count >= CW'(2)) seen_two_q <= 1'b1;
      if (pushed) begin
        ready_q <= 1'b0;
        wait_q  <= '0;
      end else if (last_out) begin
        if (seen_two_q) begin
          ready_q    <= 1'b1;
          seen_two_q <= 1'b0;
        end else begin
          wait_q <= char_ticks(cfg);
        end
      end else if (tick && (wait_q != '0)) begin
        wait_q <= wait_q - LEN_W'(1);
        if (wait_q == LEN_W'(1)) ready_q <= 1'b1;
      end
    end
  end

  AST_IRQ_ONLY_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (count == '0)); // R4

  AST_FIRST_BYTE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (pushed && (count == '0)) |=> !irq); // R5

  AST_HOLD_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_q != '0) |-> !irq); // R6

  AST_FAST_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (last_out && seen_two_q && !clr) |=> (irq || !irq_en)); // R7

  AST_ENABLE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq); // R8

  AST_CLEAR_READY: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (irq || !irq_en)); // R9

endmodule

// File: rtl/uart_txq_top.sv
module uart_txq_top
  import uart_txq_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ready,
  input  logic              irq_en,
  input  logic              fifo_clr,
  input  logic              bit_tick,
  input  logic [1:0]        word_len,
  input  logic              parity_en,
  input  logic              two_stop,
  output logic              txd,
  output logic              fifo_full,
  output logic              irq
);

  line_cfg_t         cfg;
  logic              pushed, popped, busy;
  logic [DATA_W-1:0] head;
  logic [CW-1:0]     count;

  assign cfg = '{wlen: word_len, par_en: parity_en, stop2: two_stop};

  txq_fifo #(.DEPTH(DEPTH), .WIDTH(DATA_W)) u_fifo (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (fifo_clr),
    .push_valid (wr_valid),
    .push_data  (wr_data),
    .push_ready (wr_ready),
    .pop_req    (!busy),
    .pop_data   (head),
    .pushed     (pushed),
    .popped     (popped),
    .count      (count)
  );

  txq_shifter u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (bit_tick),
    .cfg       (cfg),
    .load      (popped),
    .load_data (head),
    .busy      (busy),
    .txd       (txd)
  );

  txq_irq_ctl #(.CW(CW)) u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (fifo_clr),
    .tick   (bit_tick),
    .cfg    (cfg),
    .pushed (pushed),
    .popped (popped),
    .count  (count),
    .irq_en (irq_en),
    .irq    (irq)
  );

  assign fifo_full = !wr_ready;

  AST_FULL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> (count == CW'(DEPTH))); // R1

endmodule

// File: tb/test_uart_txq_top.sv
`timescale 1ns/1ps
module test_uart_txq_top;

  localparam int TICK_DIV = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_data = '0;
  logic       wr_ready;
  logic       irq_en = 1'b0;
  logic       fifo_clr = 1'b0;
  logic       bit_tick = 1'b0;
  logic [1:0] word_len = 2'd3;
  logic       parity_en = 1'b0;
  logic       two_stop = 1'b0;
  logic       txd, fifo_full, irq;

  int checks = 0;
  int errors = 0;
  int frames_seen = 0;
  int frames_sent = 0;
  int tcnt = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];

  uart_txq_top i_uart_txq_top (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_ready(wr_ready), .irq_en(irq_en), .fifo_clr(fifo_clr),
    .bit_tick(bit_tick), .word_len(word_len), .parity_en(parity_en),
    .two_stop(two_stop), .txd(txd), .fifo_full(fifo_full), .irq(irq)
  );

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    tcnt = (tcnt == TICK_DIV - 1) ? 0 : tcnt + 1;
    bit_tick = (tcnt == TICK_DIV - 1);
  end

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic int char_len();
    return 1 + 5 + int'(word_len) + int'(parity_en) + 1 + int'(two_stop);
  endfunction

  // Scoreboard monitor: decodes each character from txd and compares it
  // against the byte the driver queued.
  initial begin : monitor
    forever begin
      @(negedge clk);
      if (rst_n && txd === 1'b0) begin
        int n;
        int nb;
        logic [11:0] got;
        logic [11:0] exp;
        logic [7:0] b;
        logic p;
        frames_seen++;
        nb = 5 + int'(word_len);
        n = char_len() - 1;
        got = '0;
        exp = '0;
        b = '0;
        if (exp_q.size() != 0) b = exp_q.pop_front();
        else chk(1'b0, "R3 unexpected character on line", 32'(frames_seen), 32'(frames_sent));
        p = 1'b0;
        for (int i = 0; i < nb; i++) begin
          exp[i] = b[i];
          p = p ^ b[i];
        end
        for (int i = nb; i < n; i++) exp[i] = 1'b1;
        if (parity_en) exp[nb] = p;
        for (int k = 0; k < n; k++) begin
          @(posedge clk iff bit_tick);
          @(negedge clk);
          got[k] = txd;
        end
        chk(got === exp, "R3 character bits after start", 32'(got), 32'(exp));
      end
    end
  end

  task automatic send(input logic [7:0] b);
    while (wr_ready !== 1'b1) begin
      wr_valid = 1'b0;
      @(negedge clk);
    end
    wr_valid = 1'b1;
    wr_data = b;
    exp_q.push_back(b);
    frames_sent++;
    @(negedge clk);
  endtask

  task automatic stop_wr();
    wr_valid = 1'b0;
  endtask

  task automatic settle();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (14 * TICK_DIV) @(negedge clk);
  endtask

  task automatic set_cfg(input logic [1:0] wl, input logic pe, input logic s2);
    word_len = wl;
    parity_en = pe;
    two_stop = s2;
    @(negedge clk);
  endtask

  // Single byte into an idle block: interrupt must drop, then stay low for
  // exactly one character time of ticks.
  task automatic single_holdback(input logic [7:0] b, input string tag);
    int l;
    l = char_len();
    send(b);
    stop_wr();
    chk(irq === 1'b0, {"R5 irq drops after first byte ", tag}, 32'(irq), 0);
    while (txd !== 1'b0) @(negedge clk);
    repeat (l - 1) @(posedge clk iff bit_tick);
    @(negedge clk);
    chk(irq === 1'b0, {"R6 irq held one tick before character time ", tag}, 32'(irq), 0);
    @(posedge clk iff bit_tick);
    @(negedge clk);
    chk(irq === 1'b1, {"R6 irq raised after character time ", tag}, 32'(irq), 1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stimulus
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(txd === 1'b1, "R3 line idles high after reset", 32'(txd), 1);
    chk(wr_ready === 1'b1, "R1 ready after reset", 32'(wr_ready), 1);
    chk(fifo_full === 1'b0, "R1 not full after reset", 32'(fifo_full), 0);
    chk(irq === 1'b0, "R8 irq low while disabled", 32'(irq), 0);
    irq_en = 1'b1;
    #1;
    chk(irq === 1'b1, "R4 irq when empty and enabled", 32'(irq), 1);
    irq_en = 1'b0;
    #1;
    chk(irq === 1'b0, "R8 disable drops irq at once", 32'(irq), 0);
    irq_en = 1'b1;
    #1;
    chk(irq === 1'b1, "R8 enable raises irq at once", 32'(irq), 1);
    @(negedge clk);

    single_holdback(8'hA5, "8N1");
    settle();

    // Three writes on consecutive cycles put two bytes in the queue at once.
    begin
      int target;
      send(8'h3C);
      send(8'hC3);
      send(8'h81);
      stop_wr();
      chk(irq === 1'b0, "R5 irq low while queue busy", 32'(irq), 0);
      target = frames_sent;
      while (frames_seen < target - 1) @(negedge clk);
      @(negedge clk);
      chk(irq === 1'b0, "R7 irq low while last byte still queued", 32'(irq), 0);
      while (frames_seen < target) @(negedge clk);
      @(negedge clk);
      chk(irq === 1'b1, "R7 irq at once after two were held", 32'(irq), 1);
    end
    settle();

    set_cfg(2'd0, 1'b1, 1'b1);
    single_holdback(8'h16, "R7 re-armed 5E2");
    settle();

    set_cfg(2'd2, 1'b1, 1'b0);
    send(8'h55);
    send(8'h2A);
    stop_wr();
    settle();

    // Fill the queue.
    set_cfg(2'd3, 1'b0, 1'b0);
    for (int i = 0; i < 17; i++) send(8'(8'h10 + i));
    stop_wr();
    chk(wr_ready === 1'b0, "R1 ready low when sixteen queued", 32'(wr_ready), 0);
    chk(fifo_full === 1'b1, "R1 full flag", 32'(fifo_full), 1);
    wr_valid = 1'b1;
    wr_data = 8'h5A;
    repeat (10) @(negedge clk);
    chk(fifo_full === 1'b1, "R1 refused write leaves queue full", 32'(fifo_full), 1);
    wr_valid = 1'b0;
    begin
      logic prev;
      int guard;
      prev = txd;
      guard = 0;
      while (wr_ready !== 1'b1 && guard < 400) begin
        prev = txd;
        @(negedge clk);
        guard++;
      end
      chk(wr_ready === 1'b1 && txd === 1'b0 && prev === 1'b1,
          "R2 ready returns with next start bit", {29'd0, wr_ready, txd, prev}, 32'b110);
    end
    settle();

    // Clear while a character is in flight, with a write in the same cycle.
    set_cfg(2'd1, 1'b0, 1'b1);
    send(8'h2D);
    send(8'h11);
    send(8'h22);
    send(8'h33);
    stop_wr();
    repeat (10) @(negedge clk);
    fifo_clr = 1'b1;
    wr_valid = 1'b1;
    wr_data = 8'hEE;
    exp_q.delete();
    @(negedge clk);
    fifo_clr = 1'b0;
    wr_valid = 1'b0;
    chk(irq === 1'b1, "R9 irq after clear", 32'(irq), 1);
    chk(wr_ready === 1'b1, "R10 clear wins over same-cycle write", 32'(wr_ready), 1);
    chk(txd === 1'b0 || txd === 1'b1, "R9 line driven during clear", 32'(txd), 0);
    frames_sent = frames_sent - 3;
    repeat (14 * TICK_DIV) @(negedge clk);
    chk(frames_seen == frames_sent, "R9 only in-flight character sent after clear",
        32'(frames_seen), 32'(frames_sent));
    single_holdback(8'h6B, "R9 re-armed by clear");
    settle();

    chk(exp_q.size() == 0, "R3 every queued byte transmitted", 32'(exp_q.size()), 0);
    chk(frames_seen == frames_sent, "R1 no refused byte transmitted",
        32'(frames_seen), 32'(frames_sent));
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule